// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block chooses which interrupt a small 8-bit microcontroller core takes next and carries out the entry into it. It samples the core's enable byte and priority byte. It also samples the request flags of four on-chip sources: two timers, a serial port and a third timer. Once per machine cycle, marked by `cycle_tick`, the block scans the sources for a winner. The scan covers the high priority level first and then the low level. Within each level the order is fixed: timer A, timer B, serial, timer C. A winner is accepted only if its level is strictly above the level currently in service.

On acceptance the block pushes the return program counter onto the stack through a byte-wide internal-RAM write port. The low byte goes to the stack pointer plus one and the high byte to the stack pointer plus two. The block then stores the new stack pointer and issues a one-cycle vector strobe with the entry address. For the two timers whose flags hardware owns, the same strobe clears the flag. A two-entry level stack records the level in service and the level that was interrupted. A `reti_pulse` pops this stack. The pulse takes effect only while the controller is idle.

The sequencer has four states. IDLE waits for a tick with a qualifying winner (transition *accept*) and otherwise stays put. PUSH_LO writes the low PC byte (transition *next byte*). PUSH_HI writes the high PC byte (transition *finish*). DONE updates the stack pointer, strobes the vector, clears the timer flag, pushes the level, and returns to IDLE (transition *return*).

Top module: `vec_irq_ctrl`

## Requirements
- R1: No interrupt is accepted while bit 7 of `en_reg` (global enable) is 0.
- R2: A source takes part only when its own `en_reg` bit is 1. The bits are: 1 for timer A, 3 for timer B, 4 for serial, 5 for timer C. The same bit of `pri_reg` selects high (1) or low (0) priority. The requests are `tmr_ctl` bit 5 (timer A), `tmr_ctl` bit 7 (timer B), `ser_ctl` bit 0 or bit 1 (serial) and `t2_ctl` bit 7 (timer C).
- R3: The vector is 0x000B for timer A, 0x001B for timer B, 0x0023 for serial and 0x002B for timer C.
- R4: High-priority candidates win over low-priority ones. Within one level the lowest-ordered source wins, in the order timer A, timer B, serial, timer C.
- R5: A candidate is accepted only if its level is strictly above `active_lvl`. The encoding of `active_lvl` is 0 = none, 1 = low, 2 = high, and it reads 0 after reset.
- R6: On entry with stack pointer S, the block first writes PC[7:0] at S+1. In the next cycle it writes PC[15:8] at S+2. In the cycle after that it drives `sp_we` with `sp_wdata` = S+2. All addresses wrap modulo 256.
- R7: `clr_tf0` pulses with the vector of timer A and `clr_tf1` pulses with the vector of timer B. The serial and timer C entries pulse neither.
- R8: Arbitration happens only in an idle cycle where `cycle_tick` is 1. Without the tick, no entry starts.
- R9: A `reti_pulse` while idle restores `active_lvl` to the level that was in service before the current one.
- R10: `vector_valid` is high for exactly one cycle, the cycle right after the two RAM writes. `active_lvl` shows the new level one cycle after `vector_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_tick | input | 1 | Machine-cycle strobe that enables arbitration |
| en_reg | input | 8 | Interrupt enable byte |
| pri_reg | input | 8 | Interrupt priority byte |
| tmr_ctl | input | 8 | Timer control byte holding the timer A and timer B flags |
| ser_ctl | input | 8 | Serial control byte holding the transmit and receive flags |
| t2_ctl | input | 8 | Timer C control byte holding its flag |
| sp_in | input | 8 | Current stack pointer |
| pc_in | input | 16 | Return program counter |
| reti_pulse | input | 1 | Return-from-interrupt strobe |
| ram_we | output | 1 | Internal RAM write enable |
| ram_addr | output | 8 | Internal RAM write address |
| ram_wdata | output | 8 | Internal RAM write data |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 8 | New stack pointer |
| clr_tf0 | output | 1 | Clear strobe for the timer A flag |
| clr_tf1 | output | 1 | Clear strobe for the timer B flag |
| vector_out | output | 16 | Entry address |
| vector_valid | output | 1 | One-cycle strobe qualifying `vector_out` |
| active_lvl | output | 2 | Level in service (0 none, 1 low, 2 high) |

## Verification
Some properties are checked on every cycle:
- The global gate and the tick both hold the sequencer in IDLE.
- The second stack write lands one address above the first.
- The stored stack pointer equals the last write address.
- The vector strobe lasts one cycle and follows two writes.
- Flag clears appear only with the strobe.
- Every accepted level is strictly above the level in service.
- A pop restores the saved level.

Which source actually wins, and which vector value it carries, can only be shown by the bench's scenarios. The same holds for respect of the per-source enables and request bits, nesting low under high, and stack-pointer wrap. In those scenarios the bench compares the ports with its own arbitration model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 4;
    localparam int SRC_W = $clog2(NSRC);
    localparam int GATE_BIT = 7;

    localparam int SRC_TA  = 0;
    localparam int SRC_TB  = 1;
    localparam int SRC_SER = 2;
    localparam int SRC_TC  = 3;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_LO = 2'd1,
        ST_PUSH_HI = 2'd2,
        ST_DONE    = 2'd3
    } st_t;

    // Position of a source's enable / priority bit.
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            default: return 5;
        endcase
    endfunction

    // Entry address of a source.
    function automatic logic [7:0] vec_of(input logic [SRC_W-1:0] idx);
        case (idx)
            2'd0:    return 8'h0B;
            2'd1:    return 8'h1B;
            2'd2:    return 8'h23;
            default: return 8'h2B;
        endcase
    endfunction
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
    import irq_pkg::*;
(
    input  logic [7:0]      en_reg,
    input  logic [7:0]      pri_reg,
    input  logic [7:0]      tmr_ctl,
    input  logic [7:0]      ser_ctl,
    input  logic [7:0]      t2_ctl,
    output logic            gate,
    output logic [NSRC-1:0] req,
    output logic [NSRC-1:0] ena,
    output logic [NSRC-1:0] hi
);
    assign gate         = en_reg[GATE_BIT];
    assign req[SRC_TA]  = tmr_ctl[5];
    assign req[SRC_TB]  = tmr_ctl[7];
    assign req[SRC_SER] = ser_ctl[0] | ser_ctl[1];
    assign req[SRC_TC]  = t2_ctl[7];

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            localparam int B = src_bit(g);
            assign ena[g] = en_reg[B];
            assign hi[g]  = pri_reg[B];
        end
    endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic             gate,
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  ena,
    input  logic [NSRC-1:0]  hi,
    input  lvl_t             cur,
    output logic             hit,
    output logic [SRC_W-1:0] sel,
    output lvl_t             lvl
);
    logic [NSRC-1:0] cand_hi;
    logic [NSRC-1:0] cand_lo;
    logic            ok_hi;
    logic            ok_lo;

    assign cand_hi = {NSRC{gate}} & ena & req & hi;
    assign cand_lo = {NSRC{gate}} & ena & req & ~hi;
    assign ok_hi   = (cur == LVL_NONE) || (cur == LVL_LOW);
    assign ok_lo   = (cur == LVL_NONE);

    function automatic logic [SRC_W-1:0] first_of(input logic [NSRC-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        hit = 1'b0;
        sel = '0;
        lvl = LVL_NONE;
        if (ok_hi && (|cand_hi)) begin
            hit = 1'b1;
            lvl = LVL_HIGH;
            sel = first_of(cand_hi);
        end else if (ok_lo && (|cand_lo)) begin
            hit = 1'b1;
            lvl = LVL_LOW;
            sel = first_of(cand_lo);
        end
    end

    // R5: a grant must outrank the level in service
    always_comb begin
        if (hit) begin
            assert_strict_above_R5: assert (lvl > cur);
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  lvl_t push_lvl,
    input  logic pop,
    output lvl_t cur,
    output lvl_t prev
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= LVL_NONE;
            prev <= LVL_NONE;
        end else if (push) begin
            prev <= cur;
            cur  <= push_lvl;
        end else if (pop) begin
            cur  <= prev;
            prev <= LVL_NONE;
        end
    end

    assert_nest_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur != LVL_NONE) |-> (cur > prev));

    assert_pop_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (cur == $past(prev)));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irq_pkg::*;
#(
    parameter int SP_W   = 8,
    parameter int DATA_W = 8,
    parameter int VEC_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cycle_tick,
    input  logic [7:0]          en_reg,
    input  logic [7:0]          pri_reg,
    input  logic [7:0]          tmr_ctl,
    input  logic [7:0]          ser_ctl,
    input  logic [7:0]          t2_ctl,
    input  logic [SP_W-1:0]     sp_in,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic                reti_pulse,
    output logic                ram_we,
    output logic [SP_W-1:0]     ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                sp_we,
    output logic [SP_W-1:0]     sp_wdata,
    output logic                clr_tf0,
    output logic                clr_tf1,
    output logic [VEC_W-1:0]    vector_out,
    output logic                vector_valid,
    output logic [1:0]          active_lvl
);
    localparam int PC_W = 2 * DATA_W;

    logic             gate;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  ena;
    logic [NSRC-1:0]  hi;
    logic             hit;
    logic [SRC_W-1:0] sel;
    lvl_t             sel_lvl;
    lvl_t             cur_lvl;
    lvl_t             prev_lvl;

    st_t              st;
    st_t              st_nxt;
    logic             accept;
    logic [SP_W-1:0]  sp_q;
    logic [PC_W-1:0]  pc_q;
    logic [7:0]       vec_q;
    logic [SRC_W-1:0] src_q;
    lvl_t             lvl_q;

    irq_req_decode u_dec (
        .en_reg  (en_reg),
        .pri_reg (pri_reg),
        .tmr_ctl (tmr_ctl),
        .ser_ctl (ser_ctl),
        .t2_ctl  (t2_ctl),
        .gate    (gate),
        .req     (req),
        .ena     (ena),
        .hi      (hi)
    );

    irq_pick u_pick (
        .gate (gate),
        .req  (req),
        .ena  (ena),
        .hi   (hi),
        .cur  (cur_lvl),
        .hit  (hit),
        .sel  (sel),
        .lvl  (sel_lvl)
    );

    irq_lvl_stack u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (st == ST_DONE),
        .push_lvl (lvl_q),
        .pop      (reti_pulse && (st == ST_IDLE)),
        .cur      (cur_lvl),
        .prev     (prev_lvl)
    );

    assign accept     = (st == ST_IDLE) && cycle_tick && hit;
    assign active_lvl = cur_lvl;
    assign vector_out = {{(VEC_W-8){1'b0}}, vec_q};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:    if (accept) st_nxt = ST_PUSH_LO;
            ST_PUSH_LO: st_nxt = ST_PUSH_HI;
            ST_PUSH_HI: st_nxt = ST_DONE;
            ST_DONE:    st_nxt = ST_IDLE;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    // Entry context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            pc_q  <= '0;
            vec_q <= '0;
            src_q <= '0;
            lvl_q <= LVL_NONE;
        end else if (accept) begin
            sp_q  <= sp_in + 1'b1;
            pc_q  <= pc_in;
            vec_q <= vec_of(sel);
            src_q <= sel;
            lvl_q <= sel_lvl;
        end else if (st == ST_PUSH_LO) begin
            sp_q  <= sp_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        ram_we       = 1'b0;
        ram_addr     = sp_q;
        ram_wdata    = '0;
        sp_we        = 1'b0;
        sp_wdata     = sp_q;
        vector_valid = 1'b0;
        clr_tf0      = 1'b0;
        clr_tf1      = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_PUSH_LO: begin
                ram_we    = 1'b1;
                ram_wdata = pc_q[DATA_W-1:0];
            end
            ST_PUSH_HI: begin
                ram_we    = 1'b1;
                ram_wdata = pc_q[PC_W-1:DATA_W];
            end
            ST_DONE: begin
                sp_we        = 1'b1;
                vector_valid = 1'b1;
                clr_tf0      = (src_q == SRC_W'(SRC_TA));
                clr_tf1      = (src_q == SRC_W'(SRC_TB));
            end
            default: ;
        endcase
    end

    assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !en_reg[GATE_BIT]) |=> (st == ST_IDLE));

    assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !cycle_tick) |=> (st == ST_IDLE));

    assert_push_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PUSH_LO) |=> (ram_we && ram_addr == SP_W'($past(ram_addr) + 1'b1)));

    assert_sp_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> (sp_wdata == $past(ram_addr)));

    assert_valid_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |-> ($past(ram_we) && $past(ram_we, 2)));

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |=> !vector_valid);

    assert_clr_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_tf0 || clr_tf1) |-> (vector_valid && $onehot0({clr_tf0, clr_tf1})));

    assert_vec_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |-> (vector_out == 16'h000B || vector_out == 16'h001B ||
                          vector_out == 16'h0023 || vector_out == 16'h002B));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cycle_tick = 1'b0;
    logic [7:0]  en_reg = '0, pri_reg = '0, tmr_ctl = '0, ser_ctl = '0, t2_ctl = '0;
    logic [7:0]  sp_in = 8'h07;
    logic [15:0] pc_in = '0;
    logic        reti_pulse = 1'b0;
    logic        ram_we, sp_we, clr_tf0, clr_tf1, vector_valid;
    logic [7:0]  ram_addr, ram_wdata, sp_wdata;
    logic [15:0] vector_out;
    logic [1:0]  active_lvl;

    int n_chk = 0;
    int n_bad = 0;
    int m_cur = 0;
    int m_prev = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vec_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
        .en_reg(en_reg), .pri_reg(pri_reg), .tmr_ctl(tmr_ctl),
        .ser_ctl(ser_ctl), .t2_ctl(t2_ctl), .sp_in(sp_in), .pc_in(pc_in),
        .reti_pulse(reti_pulse), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .clr_tf0(clr_tf0), .clr_tf1(clr_tf1), .vector_out(vector_out),
        .vector_valid(vector_valid), .active_lvl(active_lvl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench arbitration model; returns source index or -1.
    function automatic int model_pick(input logic [7:0] en, pri, tc, sc, t2c,
                                      input int cur, output int lvl);
        int bits [4] = '{1, 3, 4, 5};
        logic [3:0] rq;
        rq = {t2c[7], sc[0] | sc[1], tc[7], tc[5]};
        lvl = 0;
        if (!en[7]) return -1;
        for (int L = 1; L >= 0; L--) begin
            if (cur < L + 1) begin
                for (int s = 0; s < 4; s++) begin
                    if (en[bits[s]] && (pri[bits[s]] == L[0]) && rq[s]) begin
                        lvl = L + 1;
                        return s;
                    end
                end
            end
        end
        return -1;
    endfunction

    function automatic logic [15:0] model_vec(input int s);
        case (s)
            0: return 16'h000B;
            1: return 16'h001B;
            2: return 16'h0023;
            default: return 16'h002B;
        endcase
    endfunction

    task automatic trial(input logic [7:0] en, pri, tc, sc, t2c, sp,
                         input logic [15:0] pc, input bit tick, input string tag);
        int s, lv;
        logic [7:0] a1, a2;
        s = tick ? model_pick(en, pri, tc, sc, t2c, m_cur, lv) : -1;
        en_reg = en; pri_reg = pri; tmr_ctl = tc; ser_ctl = sc; t2_ctl = t2c;
        sp_in = sp; pc_in = pc; cycle_tick = tick;
        @(negedge clk);
        cycle_tick = 1'b0;
        if (s >= 0) begin
            a1 = sp + 8'd1;
            a2 = sp + 8'd2;
            chk(ram_we && ram_addr == a1 && ram_wdata == pc[7:0],
                {tag, " R6 low byte"}, {ram_we, ram_addr, ram_wdata}, {1'b1, a1, pc[7:0]});
            @(negedge clk);
            chk(ram_we && ram_addr == a2 && ram_wdata == pc[15:8] && !vector_valid,
                {tag, " R6 high byte"}, {ram_we, ram_addr, ram_wdata}, {1'b1, a2, pc[15:8]});
            @(negedge clk);
            chk(vector_valid && !ram_we, {tag, " R10 strobe"}, vector_valid, 1);
            chk(vector_out == model_vec(s), {tag, " R3 R4 vector"}, vector_out, model_vec(s));
            chk(sp_we && sp_wdata == a2, {tag, " R6 final sp"}, sp_wdata, a2);
            chk(clr_tf0 == (s == 0) && clr_tf1 == (s == 1), {tag, " R7 clear"},
                {clr_tf0, clr_tf1}, {s == 0, s == 1});
            m_prev = m_cur;
            m_cur = lv;
            @(negedge clk);
            chk(!vector_valid && active_lvl == m_cur, {tag, " R10 R5 level"}, active_lvl, m_cur);
        end else begin
            chk(!ram_we, {tag, " no entry"}, ram_we, 0);
            @(negedge clk);
            chk(!vector_valid && !ram_we && active_lvl == m_cur, {tag, " no entry level"},
                active_lvl, m_cur);
        end
    endtask

    task automatic reti(input string tag);
        reti_pulse = 1'b1;
        @(negedge clk);
        reti_pulse = 1'b0;
        m_cur = m_prev;
        m_prev = 0;
        chk(active_lvl == m_cur, {tag, " R9 pop"}, active_lvl, m_cur);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(active_lvl == 0 && !ram_we && !vector_valid && !sp_we, "R5 reset hold",
            active_lvl, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(active_lvl == 0 && !ram_we && !vector_valid, "R5 after reset", active_lvl, 0);

        // R1: global gate off
        trial(8'h3A, 8'h00, 8'hA0, 8'h03, 8'h80, 8'h07, 16'h1234, 1, "R1 gate off");
        // R8: no tick
        trial(8'hBA, 8'h00, 8'hA0, 8'h03, 8'h80, 8'h07, 16'h1234, 0, "R8 no tick");
        // R4: all low, timer A wins
        trial(8'hBA, 8'h00, 8'hA0, 8'h03, 8'h80, 8'h07, 16'h1234, 1, "R4 low order");
        reti("R9 back to none");
        // R4: serial high beats low timers
        trial(8'hBA, 8'h10, 8'hA0, 8'h03, 8'h80, 8'h30, 16'hBEEF, 1, "R4 high first");
        // R5: high in service blocks another high
        trial(8'hBA, 8'h20, 8'h00, 8'h00, 8'h80, 8'h40, 16'h0102, 1, "R5 blocked");
        reti("R9 pop high");
        // Nesting: low timer B, then high timer C
        trial(8'hBA, 8'h00, 8'h80, 8'h00, 8'h00, 8'h50, 16'h2222, 1, "R7 timer B");
        trial(8'hBA, 8'h00, 8'h00, 8'h00, 8'h80, 8'h60, 16'h3333, 1, "R5 low blocks low");
        trial(8'hBA, 8'h20, 8'h00, 8'h00, 8'h80, 8'h60, 16'h3333, 1, "R5 nest high");
        reti("R9 restore low");
        reti("R9 restore none");
        // R2: source disabled, then serial via either flag
        trial(8'hB0, 8'h00, 8'hA0, 8'h00, 8'h80, 8'h07, 16'h0001, 1, "R2 disabled");
        reti("R9 pop");
        trial(8'h90, 8'h00, 8'h00, 8'h01, 8'h00, 8'h07, 16'h0002, 1, "R2 serial bit0");
        reti("R9 pop");
        trial(8'h90, 8'h00, 8'h00, 8'h02, 8'h00, 8'h07, 16'h0003, 1, "R2 serial bit1");
        reti("R9 pop");
        // R6: stack pointer wrap
        trial(8'h82, 8'h00, 8'h20, 8'h00, 8'h00, 8'hFF, 16'hA55A, 1, "R6 wrap");
        reti("R9 pop");

        for (int k = 0; k < 300; k++) begin
            logic [7:0] en;
            en = 8'($urandom) | (($urandom % 4 != 0) ? 8'h80 : 8'h00);
            if ($urandom % 4 == 0) reti("R9 random");
            trial(en, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                  8'($urandom), 16'($urandom), ($urandom % 8) != 0, "R4 random");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule